// File: doc/BRIEF.md
# 4x4 Hybrid Inverse Transform with Reconstruction

This unit turns a 4x4 block of signed transform coefficients back into pixels. A 2-bit type code picks which one-dimensional kernel runs in each pass. The choices are a four-point inverse cosine kernel and a four-point inverse asymmetric sine kernel. The first pass runs over the rows of the coefficient block and the second pass runs over the columns of the intermediate result. The residual that comes out is rounded down by four bits, added to a 4x4 block of unsigned 8-bit predictor pixels, and clamped to the 8-bit range.

A caller puts a whole block of coefficients, a whole predictor block and a type code on the parallel ports, then pulses `start` for one cycle. The unit captures all three on that edge. It then works through one row per clock, followed by one column per clock. It pulses `done` when the reconstructed block is ready on `pix`. The result stays on `pix` until the next accepted block overwrites it. Type code 0 is not a hybrid type. For type 0 the unit still pulses `done`, but it raises `err` and passes the predictor through unchanged.

Top module: `hyb_itx4_recon`

## Requirements
- R1: While reset is asserted, `busy`, `done` and `err` are low and `pix` is all zeros.
- R2: A `start` seen while idle is accepted on that clock edge, and `busy` is high from the next cycle. `done` is high for exactly one cycle, starting 9 rising edges after the accepting edge is counted as edge 1. `busy` is low again in that same cycle.
- R3: Type 1 (code 01) applies the inverse cosine kernel across each row, then the inverse sine kernel down each column.
- R4: Type 2 (code 10) applies the inverse sine kernel across each row, then the inverse cosine kernel down each column.
- R5: Type 3 (code 11) applies the inverse sine kernel in both passes.
- R6: Kernel arithmetic uses the following constants. Cosine: c8=15137, c16=11585, c24=6270. Sine: s1=5283, s2=9929, s3=13377, s4=15212. The cosine kernel computes p=(x0+x2)c16, m=(x0-x2)c16, c=x1*c24-x3*c8 and s=x1*c8+x3*c24. Each of these is reduced, then it outputs p+s, m+c, m-c, p-s. The sine kernel forms a0=s1x0+s4x2+s2x3, a1=s2x0-s1x2-s4x3, a2=s3(x0-x2+x3) and a3=s3x1. It outputs the reduced values of a0+a3, a1+a3, a2 and a0+a1-a3. Reducing means (v+8192)>>>14, saturated to signed 16 bits. The final sums of the cosine kernel are also saturated to signed 16 bits.
- R7: Each second-pass value v becomes (v+8)>>>4 without overflow. That value is added to the zero-extended predictor pixel and clamped to 0..255.
- R8: For type 0 the block takes the same latency. `err` is high together with `done`, and `pix` equals the captured predictor. For types 1 to 3, `err` stays low.
- R9: A `start` that arrives while `busy` is high is ignored. It does not change the result in progress and does not cause an extra `done`.
- R10: Outside a run, `pix` holds the last result whatever the inputs do.
- R11: Element (row r, column c) sits at flat index 4r+c. Coefficient i is `coef[16i+15:16i]`, and predictor and pixel i are bits `[8i+7:8i]` of their ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a block; sampled only while idle |
| tx_type | input | 2 | Kernel pairing code, captured with start |
| coef | input | 256 | Sixteen signed 16-bit coefficients, flat index 4r+c |
| pred | input | 128 | Sixteen unsigned 8-bit predictor pixels |
| busy | output | 1 | High while a block is in progress |
| done | output | 1 | One-cycle pulse when `pix` holds the new block |
| err | output | 1 | High with `done` when the type code was 0 |
| pix | output | 128 | Sixteen reconstructed 8-bit pixels |

## Verification
The assertions assume three things about the inputs. Reset is applied before the first `start`. `start` is a request that the unit may refuse, so a pulse during a run is legal. The unit reads `tx_type`, `coef` and `pred` only on the accepting edge. The stimulus drives every input on the falling edge and holds `start` for one cycle per block. On one deliberate occasion it pulses `start` again in the middle of a run with altered data, so that the refusal is exercised. The predictor and coefficient values cover the range that reaches both pixel clamps, and include full-scale coefficients that saturate the 16-bit intermediates.

// File: rtl/hyb_itx4_recon.sv
module hyb_itx4_recon #(
  parameter int CW = 16,
  parameter int PW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [1:0]      tx_type,
  input  logic [16*CW-1:0] coef,
  input  logic [16*PW-1:0] pred,
  output logic            busy,
  output logic            done,
  output logic            err,
  output logic [16*PW-1:0] pix
);
  timeunit 1ns; timeprecision 1ps;

  localparam int AW = 2*CW + 8;
  localparam int RW = CW + 2;
  localparam logic signed [AW-1:0] K8  = AW'(15137);
  localparam logic signed [AW-1:0] K16 = AW'(11585);
  localparam logic signed [AW-1:0] K24 = AW'(6270);
  localparam logic signed [AW-1:0] S1  = AW'(5283);
  localparam logic signed [AW-1:0] S2  = AW'(9929);
  localparam logic signed [AW-1:0] S3  = AW'(13377);
  localparam logic signed [AW-1:0] S4  = AW'(15212);
  localparam logic signed [AW-1:0] HI  = AW'((longint'(1) <<< (CW-1)) - 1);
  localparam logic signed [AW-1:0] LO  = -HI - AW'(1);
  localparam logic signed [RW-1:0] PMAX = RW'((1 << PW) - 1);

  typedef enum logic [1:0] {IDLE, ROWS, COLS} st_t;

  function automatic logic signed [CW-1:0] sat(input logic signed [AW-1:0] v);
    if (v > HI) return HI[CW-1:0];
    if (v < LO) return LO[CW-1:0];
    return v[CW-1:0];
  endfunction

  function automatic logic signed [CW-1:0] r14(input logic signed [AW-1:0] v);
    return sat((v + AW'(8192)) >>> 14);
  endfunction

  function automatic logic [4*CW-1:0] kern(input logic adst, input logic [4*CW-1:0] xv);
    logic signed [AW-1:0] w0, w1, w2, w3, a0, a1, a2, a3;
    logic signed [CW-1:0] t0, t1, t2, t3, y0, y1, y2, y3;
    w0 = AW'($signed(xv[0*CW +: CW]));
    w1 = AW'($signed(xv[1*CW +: CW]));
    w2 = AW'($signed(xv[2*CW +: CW]));
    w3 = AW'($signed(xv[3*CW +: CW]));
    if (!adst) begin
      t0 = r14((w0 + w2) * K16);
      t1 = r14((w0 - w2) * K16);
      t2 = r14(w1 * K24 - w3 * K8);
      t3 = r14(w1 * K8 + w3 * K24);
      y0 = sat(AW'(t0) + AW'(t3));
      y1 = sat(AW'(t1) + AW'(t2));
      y2 = sat(AW'(t1) - AW'(t2));
      y3 = sat(AW'(t0) - AW'(t3));
    end else begin
      a0 = S1 * w0 + S4 * w2 + S2 * w3;
      a1 = S2 * w0 - S1 * w2 - S4 * w3;
      a2 = S3 * (w0 - w2 + w3);
      a3 = S3 * w1;
      y0 = r14(a0 + a3);
      y1 = r14(a1 + a3);
      y2 = r14(a2);
      y3 = r14(a0 + a1 - a3);
    end
    return {y3, y2, y1, y0};
  endfunction

  function automatic logic [PW-1:0] recon(input logic signed [CW-1:0] v, input logic [PW-1:0] p);
    logic signed [RW-1:0] r, s;
    r = (RW'(v) + RW'(8)) >>> 4;
    s = r + $signed(RW'({1'b0, p}));
    if (s < 0) return '0;
    if (s > PMAX) return '1;
    return s[PW-1:0];
  endfunction

  st_t st;
  logic [1:0] idx, ty;
  logic bad;
  logic [CW-1:0] cq [16];
  logic [CW-1:0] mq [16];
  logic [PW-1:0] pq [16];
  logic [PW-1:0] oq [16];
  logic [4*CW-1:0] kin, kout;
  logic use_adst;

  assign busy = (st != IDLE);
  assign err  = done & bad;
  assign use_adst = (st == COLS) ? ty[0] : ty[1];
  assign kout = kern(use_adst, kin);

  always_comb begin
    for (int k = 0; k < 4; k++)
      kin[k*CW +: CW] = (st == COLS) ? mq[4*k + int'(idx)] : cq[4*int'(idx) + k];
  end

  always_comb begin
    for (int i = 0; i < 16; i++) pix[i*PW +: PW] = oq[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= IDLE;
      idx  <= '0;
      ty   <= '0;
      bad  <= 1'b0;
      done <= 1'b0;
      for (int i = 0; i < 16; i++) begin
        cq[i] <= '0;
        mq[i] <= '0;
        pq[i] <= '0;
        oq[i] <= '0;
      end
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (start) begin
          st  <= ROWS;
          idx <= '0;
          ty  <= tx_type;
          bad <= (tx_type == 2'd0);
          for (int i = 0; i < 16; i++) begin
            cq[i] <= coef[i*CW +: CW];
            pq[i] <= pred[i*PW +: PW];
          end
        end
        ROWS: begin
          for (int k = 0; k < 4; k++) mq[4*int'(idx) + k] <= kout[k*CW +: CW];
          idx <= idx + 2'd1;
          if (idx == 2'd3) st <= COLS;
        end
        COLS: begin
          for (int k = 0; k < 4; k++)
            oq[4*k + int'(idx)] <= bad ? pq[4*k + int'(idx)]
                                       : recon(kout[k*CW +: CW], pq[4*k + int'(idx)]);
          idx <= idx + 2'd1;
          if (idx == 2'd3) begin
            st   <= IDLE;
            done <= 1'b1;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module hyb_itx4_recon_chk #(
  parameter int PW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic            err,
  input logic [16*PW-1:0] pix
);
  timeunit 1ns; timeprecision 1ps;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R2
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy); // R2
  AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n) done |-> ($past(busy) && $past(busy, 8) && !busy)); // R2
  AST_RUN_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done); // R9
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) err |-> done); // R8
  AST_PIX_HELD: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !done) |-> $stable(pix)); // R10
endmodule

bind hyb_itx4_recon hyb_itx4_recon_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .done(done), .err(err), .pix(pix)
);

// File: tb/hyb_itx4_recon_bench.sv
module hyb_itx4_recon_bench;
  timeunit 1ns; timeprecision 1ps;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] tx_type = 2'd0;
  logic [255:0] coef = '0;
  logic [127:0] pred = '0;
  logic busy, done, err;
  logic [127:0] pix;

  int checks = 0, errors = 0, cyc = 0;
  int cin [16];
  int pin [16];
  logic [127:0] last_px = '0;

  typedef struct { logic [127:0] px; bit er; int t0; string tag; } exp_t;
  exp_t q [$];

  hyb_itx4_recon u_hyb_itx4_recon (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_type(tx_type),
    .coef(coef), .pred(pred), .busy(busy), .done(done), .err(err), .pix(pix)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint sat16(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic longint rs14(longint v);
    return sat16((v + 8192) >>> 14);
  endfunction

  function automatic void kern1(input bit ad, input longint x [4], output longint y [4]);
    longint p, m, c, s, a0, a1, a2, a3;
    if (!ad) begin
      p = rs14((x[0] + x[2]) * 11585);
      m = rs14((x[0] - x[2]) * 11585);
      c = rs14(x[1] * 6270 - x[3] * 15137);
      s = rs14(x[1] * 15137 + x[3] * 6270);
      y[0] = sat16(p + s); y[1] = sat16(m + c);
      y[2] = sat16(m - c); y[3] = sat16(p - s);
    end else begin
      a0 = 5283 * x[0] + 15212 * x[2] + 9929 * x[3];
      a1 = 9929 * x[0] - 5283 * x[2] - 15212 * x[3];
      a2 = 13377 * (x[0] - x[2] + x[3]);
      a3 = 13377 * x[1];
      y[0] = rs14(a0 + a3); y[1] = rs14(a1 + a3);
      y[2] = rs14(a2);      y[3] = rs14(a0 + a1 - a3);
    end
  endfunction

  function automatic logic [127:0] model(input int t);
    longint m [16];
    longint x [4];
    longint y [4];
    logic [127:0] r;
    longint v;
    for (int i = 0; i < 16; i++) r[i*8 +: 8] = 8'(pin[i]);
    if (t == 0) return r;
    for (int rr = 0; rr < 4; rr++) begin
      for (int k = 0; k < 4; k++) x[k] = cin[4*rr + k];
      kern1(t >= 2, x, y);
      for (int k = 0; k < 4; k++) m[4*rr + k] = y[k];
    end
    for (int c = 0; c < 4; c++) begin
      for (int k = 0; k < 4; k++) x[k] = m[4*k + c];
      kern1(t == 1 || t == 3, x, y);
      for (int k = 0; k < 4; k++) begin
        v = ((y[k] + 8) >>> 4) + pin[4*k + c];
        if (v < 0) v = 0;
        if (v > 255) v = 255;
        r[(4*k + c)*8 +: 8] = 8'(v);
      end
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9 unexpected done actual 1 expected 0");
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(pix == e.px, e.tag, "pixels", pix, e.px);
        chk(err == e.er, "R8", "err", 128'(err), 128'(e.er));
        chk(busy == 1'b0, "R2", "busy at done", 128'(busy), 128'd0);
        chk(cyc - e.t0 == 9, "R2", "latency", 128'(cyc - e.t0), 128'd9);
      end
    end
  end

  task automatic run_block(input int t, input string tag, input bit inject);
    exp_t e;
    @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      coef[i*16 +: 16] = 16'(cin[i]);
      pred[i*8 +: 8]   = 8'(pin[i]);
    end
    tx_type = 2'(t);
    e.px = model(t);
    e.er = (t == 0);
    e.tag = tag;
    e.t0 = cyc;
    q.push_back(e);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2", "busy after start", 128'(busy), 128'd1);
    if (inject) begin
      repeat (2) @(negedge clk);
      start = 1'b1; tx_type = ~tx_type; coef = ~coef; pred = ~pred;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    last_px = e.px;
    @(negedge clk);
  endtask

  task automatic fill(input int cv, input int pv);
    for (int i = 0; i < 16; i++) begin cin[i] = cv; pin[i] = pv; end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1", "busy in reset", 128'(busy), 128'd0);
    chk(done == 1'b0, "R1", "done in reset", 128'(done), 128'd0);
    chk(err == 1'b0, "R1", "err in reset", 128'(err), 128'd0);
    chk(pix == '0, "R1", "pix in reset", pix, 128'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    fill(0, 0);
    for (int i = 0; i < 16; i++) pin[i] = 16 * i + 3;
    run_block(1, "R3", 1'b0);

    fill(0, 100); cin[0] = 640;
    run_block(1, "R3", 1'b0);

    fill(0, 60);
    for (int i = 0; i < 16; i++) cin[i] = (i % 5) * 37 - 70;
    run_block(2, "R4", 1'b0);

    fill(0, 128);
    for (int i = 0; i < 16; i++) cin[i] = 90 - 13 * i;
    run_block(3, "R5", 1'b0);

    fill(0, 240); cin[0] = 2000; cin[5] = 700;
    run_block(3, "R7", 1'b0);

    fill(0, 10); cin[0] = -2000; cin[2] = -500;
    run_block(1, "R7", 1'b0);

    fill(32767, 0);
    run_block(3, "R6", 1'b0);
    fill(-32768, 255);
    run_block(2, "R6", 1'b0);
    fill(0, 77); cin[1] = 32767; cin[3] = -32768;
    run_block(1, "R6", 1'b0);

    fill(0, 50); cin[1] = 400;
    run_block(1, "R11", 1'b0);
    fill(0, 50); cin[4] = 400;
    run_block(2, "R11", 1'b0);

    for (int n = 0; n < 9; n++) begin
      for (int i = 0; i < 16; i++) begin
        cin[i] = int'($urandom_range(0, 1200)) - 600;
        pin[i] = int'($urandom_range(0, 255));
      end
      case (n % 3)
        0: run_block(1, "R3", 1'b0);
        1: run_block(2, "R4", 1'b0);
        default: run_block(3, "R5", 1'b0);
      endcase
    end

    fill(500, 33); pin[7] = 200;
    run_block(0, "R8", 1'b0);

    fill(0, 90); cin[0] = 300; cin[6] = -120;
    run_block(2, "R9", 1'b1);
    repeat (12) @(negedge clk);
    chk(pix == last_px, "R9", "result after ignored start", pix, last_px);

    @(negedge clk);
    coef = ~coef; pred = ~pred; tx_type = 2'd3;
    repeat (6) @(negedge clk);
    chk(pix == last_px, "R10", "pix hold", pix, last_px);
    chk(q.size() == 0, "R9", "pending items", 128'(q.size()), 128'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R2 watchdog actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule